// File: doc/BRIEF.md
# Quarter-Phase Sampling Time-to-Digital Converter

This block timestamps transitions on a single logic input to a quarter of a core-clock period. Four capture flops, clocked at 0°, 90°, 180° and 270° of the core clock, produce four phase samples per core cycle. Those capture flops sit outside the block, and their outputs enter here as a 4-bit word. The block re-registers the word through two alignment layers into the core clock domain. It joins the samples of three consecutive cycles into one time-ordered bit pattern. A single detect-and-filter path then searches that pattern for a clean edge. Each accepted edge is reported as a 2-bit fine phase code, a coarse time tag taken from a free-running counter, and an edge-type bit. All of these are qualified by a one-cycle valid strobe. At a 360 MHz core clock, one fine bin is about 0.69 ns.

Bit p of the input word is the sample taken at phase p×90°, so bit 0 is the earliest in time. An edge counts only when the old level holds for two bins before the transition and the new level holds for two bins after it. This rejects ringing and runt pulses. In the default mode only rising (leading) edges are reported. A mode input adds falling edges, and the edge-type bit then tells them apart. The result stream is a valid-only interface with no back-pressure: the consumer must accept every strobe in the cycle it appears. An arrival cannot be held back, so no ready signal exists.

Top module: `tdc_multiphase`

## Requirements
- R1: While `rst` is high, `ev_valid` is low. A synchronous reset clears the coarse counter, and the pipeline registers reset to the low level.
- R2: Take a word presented at the k-th rising clock edge after `rst` falls, with k = 0 for the first edge. An edge found in that word is reported with `ev_valid` high after edge k+3, and `ev_coarse` equals k modulo 2^CNT_W.
- R3: `ev_fine` is the phase index (0 to 3) of the first sample at the new level. An edge at phase 0 is found by using the samples from the previous cycle.
- R4: Consider the four pattern bits from two bins before to one bin after a transition, in time order. The edge is accepted only if they read 0,0,1,1 (rising) or 1,1,0,0 (falling). A pulse or dip one bin wide produces no report.
- R5: With `both_edges` low, falling edges are never reported, and every report has `ev_rising` high.
- R6: With `both_edges` high, falling edges are reported with `ev_rising` low, and rising edges with `ev_rising` high.
- R7: At most one edge is reported per core cycle. If several edges are accepted in one word, the earliest phase wins and the rest are dropped.
- R8: The coarse counter steps by one every cycle outside reset and wraps silently from 2^CNT_W−1 to 0.
- R9: `ev_valid` is high for exactly one cycle per reported edge, and stays low in cycles whose word holds no accepted edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (0° phase) |
| rst | input | 1 | Synchronous active-high reset |
| phase_word | input | PHASES (4) | Phase samples for one cycle; bit p was taken at p×90° |
| both_edges | input | 1 | 0: rising edges only; 1: rising and falling edges |
| ev_valid | output | 1 | One-cycle strobe for a reported edge |
| ev_fine | output | log2(PHASES) (2) | Fine phase code of the reported edge |
| ev_rising | output | 1 | Edge type: 1 rising, 0 falling |
| ev_coarse | output | CNT_W (4) | Coarse cycle tag of the reported edge |

## Verification
The internal state of this block is the aligned sample history, the previous-cycle tail and the coarse counter. Each of them shows at the ports within three cycles of the word it affects. A stale or missing history register gives a wrong fine code for phase-0 edges, or a false report at a cycle boundary, on the very next edge. A counter that slips or is not cleared shifts every later coarse tag by a constant, so one edge after reset exposes it. Filter faults show up as runt pulses that get reported, or as clean edges that are lost. The bench looks for both in each cycle, because it compares the strobe in every cycle and not only in cycles where a report is expected.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2
  } edge_cls_t;

  // Window bit 0 is the oldest sample. A clean transition needs two bins
  // of the old level followed by two bins of the new level.
  function automatic edge_cls_t classify(input logic [3:0] win);
    if (win == 4'b1100)
      return EDGE_RISE;
    else if (win == 4'b0011)
      return EDGE_FALL;
    else
      return EDGE_NONE;
  endfunction

endpackage

// File: rtl/tdc_align.sv
module tdc_align #(
  parameter int PHASES = 4,
  parameter int DEPTH  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PHASES-1:0] samp_in,
  output logic [PHASES-1:0] samp_out
);

  logic [PHASES-1:0] stage [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_layer
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= '0;
          else     stage[0] <= samp_in;
        end
        // R2
        first_layer_chk: assert property (@(posedge clk) disable iff (rst)
          !rst |=> (stage[0] == $past(samp_in)));
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= '0;
          else     stage[i] <= stage[i-1];
        end
        // R2
        next_layer_chk: assert property (@(posedge clk) disable iff (rst)
          !rst |=> (stage[i] == $past(stage[i-1])));
      end
    end
  endgenerate

  assign samp_out = stage[DEPTH-1];

endmodule

// File: rtl/tdc_edge_filter.sv
module tdc_edge_filter
  import tdc_pkg::*;
#(
  parameter int PHASES = 4,
  localparam int FINE_W = $clog2(PHASES)
) (
  input  logic [1:0]        older_tail,
  input  logic [PHASES-1:0] mid,
  input  logic              newer_head,
  input  logic              both_en,
  output logic              hit,
  output logic [FINE_W-1:0] fine,
  output logic              rise
);

  localparam int PAT_W = PHASES + 3;

  logic [PAT_W-1:0]  pattern;
  logic [PHASES-1:0] is_rise;
  logic [PHASES-1:0] is_fall;
  logic [PHASES-1:0] cand;

  // Time order from bit 0: two bins of the previous cycle, the cycle being
  // evaluated, then one bin of the following cycle.
  assign pattern = {newer_head, mid, older_tail};

  generate
    for (genvar k = 0; k < PHASES; k++) begin : g_tap
      logic [3:0] win;
      edge_cls_t  cls;
      assign win        = pattern[k+3 -: 4];
      assign cls        = classify(win);
      assign is_rise[k] = (cls == EDGE_RISE);
      assign is_fall[k] = (cls == EDGE_FALL);
      assign cand[k]    = is_rise[k] | (both_en & is_fall[k]);
    end
  endgenerate

  // Earliest phase wins; later edges in the same cycle are dropped.
  always_comb begin
    hit  = 1'b0;
    fine = '0;
    rise = 1'b0;
    for (int k = PHASES - 1; k >= 0; k--) begin
      if (cand[k]) begin
        hit  = 1'b1;
        fine = FINE_W'(k);
        rise = is_rise[k];
      end
    end
  end

endmodule

// File: rtl/tdc_coarse_ctr.sv
module tdc_coarse_ctr #(
  parameter int CNT_W = 4,
  parameter int LAT   = 3
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] tag
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  // The tag names the cycle in which the word was captured, LAT cycles
  // before the output register loads it.
  assign tag = cnt - CNT_W'(LAT);

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/tdc_multiphase.sv
module tdc_multiphase
  import tdc_pkg::*;
#(
  parameter int PHASES = 4,
  parameter int CNT_W  = 4,
  localparam int FINE_W = $clog2(PHASES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PHASES-1:0] phase_word,
  input  logic              both_edges,
  output logic              ev_valid,
  output logic [FINE_W-1:0] ev_fine,
  output logic              ev_rising,
  output logic [CNT_W-1:0]  ev_coarse
);

  localparam int ALIGN_DEPTH = 2;
  localparam int PIPE_LAT    = ALIGN_DEPTH + 1;

  logic [PHASES-1:0] aligned;
  logic [PHASES-1:0] mid_q;
  logic [1:0]        tail_q;
  logic              hit;
  logic [FINE_W-1:0] hit_fine;
  logic              hit_rise;
  logic [CNT_W-1:0]  tag;
  logic              rst_q;

  tdc_align #(.PHASES(PHASES), .DEPTH(ALIGN_DEPTH)) u_align (
    .clk      (clk),
    .rst      (rst),
    .samp_in  (phase_word),
    .samp_out (aligned)
  );

  // Three-cycle history: the tail of the older word, the word being
  // evaluated, and the newest aligned word.
  always_ff @(posedge clk) begin
    if (rst) begin
      mid_q  <= '0;
      tail_q <= '0;
    end else begin
      mid_q  <= aligned;
      tail_q <= mid_q[PHASES-1 -: 2];
    end
  end

  tdc_edge_filter #(.PHASES(PHASES)) u_filter (
    .older_tail (tail_q),
    .mid        (mid_q),
    .newer_head (aligned[0]),
    .both_en    (both_edges),
    .hit        (hit),
    .fine       (hit_fine),
    .rise       (hit_rise)
  );

  tdc_coarse_ctr #(.CNT_W(CNT_W), .LAT(PIPE_LAT)) u_coarse (
    .clk (clk),
    .rst (rst),
    .tag (tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_valid  <= 1'b0;
      ev_fine   <= '0;
      ev_rising <= 1'b0;
      ev_coarse <= '0;
    end else begin
      ev_valid <= hit;
      if (hit) begin
        ev_fine   <= hit_fine;
        ev_rising <= hit_rise;
        ev_coarse <= tag;
      end
    end
  end

  always_ff @(posedge clk) rst_q <= rst;

  // R1
  always @(posedge clk) begin
    if (rst_q) begin
      reset_quiet_chk: assert (!ev_valid);
    end
  end

  // R5
  lead_only_chk: assert property (@(posedge clk) disable iff (rst)
    (hit && !both_edges) |=> (ev_valid && ev_rising));

  // R9
  strobe_follows_chk: assert property (@(posedge clk) disable iff (rst)
    !hit |=> !ev_valid);

endmodule

// File: tb/tdc_multiphase_bench.sv
module tdc_multiphase_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] phase_word = 4'h0;
  logic       both_edges = 1'b0;
  logic       ev_valid;
  logic [1:0] ev_fine;
  logic       ev_rising;
  logic [3:0] ev_coarse;

  int checks = 0;
  int fails  = 0;
  int nw     = 0;
  int seen   = 0;
  bit done   = 0;
  logic [3:0] wq [0:1023];

  always #(CLK_PERIOD/2) clk = ~clk;

  tdc_multiphase u_tdc_multiphase (
    .clk        (clk),
    .rst        (rst),
    .phase_word (phase_word),
    .both_edges (both_edges),
    .ev_valid   (ev_valid),
    .ev_fine    (ev_fine),
    .ev_rising  (ev_rising),
    .ev_coarse  (ev_coarse)
  );

  function automatic logic [3:0] wd(input int i);
    if (i < 0) return 4'h0;
    return wq[i];
  endfunction

  // Returns {hit, fine[1:0], rise}, following the window rule of R4 and the
  // earliest-phase priority of R7.
  function automatic logic [3:0] ref_eval(input int mi, input logic both);
    logic [11:0] b;
    b = {wd(mi + 1), wd(mi), wd(mi - 1)};
    for (int k = 0; k < 4; k++) begin
      logic [3:0] win;
      win = b[4 + k + 1 -: 4];
      if (win == 4'b1100) return {1'b1, 2'(k), 1'b1};
      if (both && win == 4'b0011) return {1'b1, 2'(k), 1'b0};
    end
    return 4'b0000;
  endfunction

  task automatic check(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // Drives one word and compares the output of the edge that just occurred.
  task automatic step(input logic [3:0] w, input string req);
    logic [3:0] e;
    int mi;
    phase_word = w;
    wq[nw] = w;
    nw++;
    @(negedge clk);
    mi = nw - 4;
    e  = ref_eval(mi, both_edges);
    if (ev_valid === 1'b1) seen++;
    check((ev_valid === e[3]) &&
          (!e[3] || (ev_fine === e[2:1] && ev_rising === e[0] &&
                     ev_coarse === 4'(mi))),
          req,
          $sformatf("got v=%b f=%0d r=%b c=%0d exp v=%b f=%0d r=%b c=%0d",
                    ev_valid, ev_fine, ev_rising, ev_coarse,
                    e[3], e[2:1], e[0], 4'(mi)));
  endtask

  task automatic idle(input int n, input logic [3:0] lvl, input string req);
    for (int i = 0; i < n; i++) step(lvl, req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    phase_word = 4'h0;
    repeat (3) @(negedge clk);
    // R1: the strobe stays low during reset
    check(ev_valid === 1'b0, "R1",
          $sformatf("got ev_valid=%b exp 0 in reset", ev_valid));
    rst = 1'b0;
    nw = 0;
  endtask

  // R3 and R5: a rising edge at each phase; the falling edges are not reported
  task automatic t_each_phase();
    both_edges = 1'b0;
    seen = 0;
    for (int p = 0; p < 4; p++) begin
      idle(3, 4'h0, "R5");
      step(4'(4'hF << p), "R3");
      idle(3, 4'hF, "R3");
      step(4'(4'hF >> (4 - p)), "R5");
    end
    idle(4, 4'h0, "R5");
    check(seen == 4, "R5", $sformatf("got %0d reports exp 4", seen));
  endtask

  // R4: a glitch or a dip one bin wide is rejected
  task automatic t_runts();
    both_edges = 1'b1;
    idle(4, 4'h0, "R4");
    seen = 0;
    step(4'b0100, "R4");
    idle(3, 4'h0, "R4");
    step(4'b1000, "R4");
    step(4'b0000, "R4");
    idle(3, 4'h0, "R4");
    check(seen == 0, "R4", $sformatf("glitch: got %0d reports exp 0", seen));
    idle(4, 4'hF, "R6");
    seen = 0;
    step(4'b1011, "R4");
    idle(4, 4'hF, "R4");
    check(seen == 0, "R4", $sformatf("dip: got %0d reports exp 0", seen));
    step(4'h0, "R6");
    idle(4, 4'h0, "R6");
    both_edges = 1'b0;
  endtask

  // R6 and R7: both-edge mode, plus two edges inside one word
  task automatic t_both_edges();
    both_edges = 1'b1;
    idle(4, 4'h0, "R6");
    seen = 0;
    step(4'b0110, "R7");
    idle(4, 4'h0, "R7");
    check(seen == 1, "R7", $sformatf("got %0d reports exp 1", seen));
    seen = 0;
    step(4'b1100, "R6");
    idle(3, 4'hF, "R6");
    step(4'b0011, "R6");
    idle(4, 4'h0, "R6");
    check(seen == 2, "R6", $sformatf("got %0d reports exp 2", seen));
    both_edges = 1'b0;
  endtask

  // R3 and R9: edges at cycle boundaries and in adjacent cycles
  task automatic t_boundary();
    both_edges = 1'b1;
    idle(3, 4'h0, "R9");
    seen = 0;
    step(4'b1000, "R3");
    step(4'b1111, "R3");
    step(4'b0000, "R9");
    step(4'b1100, "R9");
    step(4'b0000, "R9");
    idle(4, 4'h0, "R9");
    check(seen == 4, "R9", $sformatf("got %0d reports exp 4", seen));
    both_edges = 1'b0;
  endtask

  // R8 and R2: tags wrap past 2^4 cycles; a second reset restarts them
  task automatic t_wrap();
    idle(20, 4'h0, "R8");
    step(4'b1110, "R8");
    idle(6, 4'hF, "R8");
    idle(5, 4'h0, "R8");
    do_reset();
    idle(2, 4'h0, "R2");
    step(4'b1111, "R2");
    idle(5, 4'hF, "R2");
    idle(4, 4'h0, "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    t_each_phase();
    t_runts();
    t_both_edges();
    t_boundary();
    t_wrap();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule